// File: doc/BRIEF.md
# Converter Calibration and Data-Ready Sequencer

This block is the digital sequencer that sits beside a sigma-delta modulator. It decides when a conversion result is ready, and it drives the active-low data-ready flag. It also runs the three calibration sequences. These are self-calibration, zero-scale system calibration and full-scale system calibration. Timing comes from two sources. One is a one-cycle strobe that marks each output-data-rate period. The other is the master clock, which is used for the modulator-cycle alignment and the power-up settling delay. The filter arithmetic and the calibration coefficients are computed elsewhere. In place of a real value, the block loads a placeholder result, which is a running count of completed conversions.

Software writes a two-bit mode field and a filter-sync bit through the setup write strobe. It writes a power-down bit through the communications write strobe. The mode field clears itself when a calibration finishes. Power-down freezes the sequencer and keeps the state that software can see. Leaving power-down starts a settling period and then a fresh result.

Top module: `cal_drdy_seq`

## Requirements
- R1: During and right after reset, `drdy_n` is 1, `mode_rd` is 00, `pwrdn_rd` is 0, `result` is 0 and `clk_out` is 0.
- R2: In normal mode (mode 00), each `odr_tick` loads `result` with its previous value plus one and drives `drdy_n` low on the next cycle. A `data_rd` pulse returns `drdy_n` high. Each fall of `drdy_n` carries exactly one new result.
- R3: A setup write of mode 01 with filter-sync 0 starts self-calibration. `mode_rd` reads 01 until the 6th following tick and 00 after it. `drdy_n` falls after the 9th tick.
- R4: A setup write of mode 10 with filter-sync 0 starts zero-scale calibration. `mode_rd` clears after the 3rd tick and `drdy_n` falls after the 4th.
- R5: A setup write of mode 11 starts full-scale calibration whatever the filter-sync value. `mode_rd` clears after the 3rd tick and `drdy_n` falls after the 4th.
- R6: Whenever `drdy_n` falls, `mode_rd` reads 00.
- R7: After a calibration start, `drdy_n` is high no later than MOD_CLKS+1 clocks after the write if it was low. If it was high, it stays high until the calibration result. Ticks inside a calibration load no result.
- R8: A calibration write that arrives during a calibration aborts it and restarts the count from zero with the new mode.
- R9: A setup write of mode 01 or 10 with filter-sync 1 is ignored: `mode_rd` is unchanged and the running sequence is undisturbed.
- R10: While `pwrdn_rd` is 1, `result` is frozen, ticks are ignored and the level of `drdy_n` at entry is kept. Setup writes still update `mode_rd`.
- R11: If `drdy_n` is low in power-down, a `data_rd` drives it high. If no read comes, it stays low until the power-down bit is written 0, and it goes high on the next cycle.
- R12: If `drdy_n` is high when power-down is entered, it stays high through power-down.
- R13: After power-down is cleared, PWRUP_CLKS clocks pass during which ticks are ignored. The stored mode then runs. Mode 00 gives a result after 3 further ticks, and a calibration mode runs its full sequence.
- R14: With `clkout_off` 0, `clk_out` toggles every clock, including in power-down. With `clkout_off` 1, it is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| odr_tick | input | 1 | One-cycle strobe per output-data-rate period |
| setup_wr | input | 1 | Setup register write strobe |
| setup_mode | input | 2 | Mode field: 00 normal, 01 self, 10 zero-scale, 11 full-scale |
| setup_fsync | input | 1 | Filter-sync bit written with the mode |
| comm_wr | input | 1 | Communications register write strobe |
| comm_pwrdn | input | 1 | Power-down bit written with comm_wr |
| clkout_off | input | 1 | 1 holds the clock output low |
| data_rd | input | 1 | Pulse marking completion of a data register read |
| drdy_n | output | 1 | Active-low data-ready flag |
| mode_rd | output | 2 | Current mode field |
| pwrdn_rd | output | 1 | Current power-down bit |
| result | output | DATA_W | Data register (placeholder conversion count) |
| clk_out | output | 1 | Clock output, half the master clock rate |

## Verification
Some properties are checked by the assertions on every cycle. When data-ready falls, the mode field is clear and the result has just changed. Across power-down, the result stays frozen and the data-ready level is held. The clock output toggles, or is held low when disabled. A counter bounds how long data-ready can stay low after a calibration start. Other behaviour can only be shown by the bench's scenarios. This covers the exact tick counts of each calibration type and the moment the mode bits clear. It also covers the abort-and-restart on a second write, the ignored filter-sync writes, the ignored ticks during the power-up delay, and the mode that a write made during power-down leaves behind.

// File: rtl/cds_pkg.sv
// Shared types for the calibration and data-ready sequencer.
// Assumes: mode field encoding fixed by the register decode.
package cds_pkg;
    typedef enum logic [1:0] {
        SQ_CONV = 2'd0,
        SQ_SEQ  = 2'd1,
        SQ_PD   = 2'd2,
        SQ_WAKE = 2'd3
    } sq_state_t;

    localparam logic [1:0] MD_NORMAL = 2'b00;
    localparam logic [1:0] MD_SELF   = 2'b01;
    localparam logic [1:0] MD_ZERO   = 2'b10;
    localparam logic [1:0] MD_FULL   = 2'b11;
endpackage

// File: rtl/cds_regs.sv
// Holds the mode field and power-down bit and decodes the write strobes.
// Assumes: cal_done is a one-cycle pulse; a write in the same cycle wins.
module cds_regs
    import cds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       setup_wr,
    input  logic [1:0] setup_mode,
    input  logic       setup_fsync,
    input  logic       comm_wr,
    input  logic       comm_pwrdn,
    input  logic       cal_done,
    output logic [1:0] mode_q,
    output logic       pd_q,
    output logic       wr_acc,
    output logic       pd_enter,
    output logic       pd_exit
);
    // Decode which writes take effect this cycle.
    always_comb begin
        wr_acc   = setup_wr && !(setup_fsync && (setup_mode == MD_SELF || setup_mode == MD_ZERO));
        pd_enter = comm_wr && comm_pwrdn && !pd_q;
        pd_exit  = comm_wr && !comm_pwrdn && pd_q;
    end

    // Mode field: written by software, cleared when a calibration ends.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= MD_NORMAL;
        else if (wr_acc)   mode_q <= setup_mode;
        else if (cal_done) mode_q <= MD_NORMAL;
    end

    // Power-down bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       pd_q <= 1'b0;
        else if (comm_wr) pd_q <= comm_pwrdn;
    end
endmodule

// File: rtl/cds_timebase.sv
// Free-running modulator-cycle counter and clock output divider.
// Assumes: MOD_CLKS >= 2; the counter keeps running through power-down.
module cds_timebase #(
    parameter int MOD_CLKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clkout_off,
    output logic mod_edge,
    output logic clk_out
);
    localparam int MOD_W = $clog2(MOD_CLKS);
    localparam logic [MOD_W-1:0] MOD_LAST = MOD_W'(MOD_CLKS - 1);
    localparam logic [MOD_W-1:0] MOD_ONE  = MOD_W'(1);

    logic [MOD_W-1:0] mod_cnt;

    // Count master clocks within one modulator cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                mod_cnt <= '0;
        else if (mod_cnt == MOD_LAST) mod_cnt <= '0;
        else                       mod_cnt <= mod_cnt + MOD_ONE;
    end

    // Mark the last clock of each modulator cycle.
    always_comb mod_edge = (mod_cnt == MOD_LAST);

    // Divide the master clock by two unless the output is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clkout_off) clk_out <= 1'b0;
        else                      clk_out <= ~clk_out;
    end
endmodule

// File: rtl/cds_fsm.sv
// Sequencer core: counts data-rate periods for conversions and calibrations,
// runs the power-up delay, drives data-ready and loads the placeholder result.
// Assumes: one odr_tick is far more than MOD_CLKS clocks after a start write.
module cds_fsm
    import cds_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int SELF_CAL_PER  = 6,
    parameter int SELF_CONV_PER = 3,
    parameter int SYS_CAL_PER   = 3,
    parameter int SYS_CONV_PER  = 1,
    parameter int WAKE_PER      = 3,
    parameter int PWRUP_CLKS    = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              odr_tick,
    input  logic              data_rd,
    input  logic              mod_edge,
    input  logic              wr_acc,
    input  logic [1:0]        setup_mode,
    input  logic [1:0]        mode_q,
    input  logic              pd_enter,
    input  logic              pd_exit,
    output logic              cal_done,
    output logic              drdy_n,
    output logic [DATA_W-1:0] result
);
    localparam int SELF_TOT = SELF_CAL_PER + SELF_CONV_PER;
    localparam int SYS_TOT  = SYS_CAL_PER + SYS_CONV_PER;
    localparam int MAX_A    = (SELF_TOT > SYS_TOT) ? SELF_TOT : SYS_TOT;
    localparam int MAX_PER  = (MAX_A > WAKE_PER) ? MAX_A : WAKE_PER;
    localparam int CNT_W    = $clog2(MAX_PER + 1);
    localparam int WAKE_W   = $clog2(PWRUP_CLKS);
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
    localparam logic [WAKE_W-1:0] WAKE_ONE  = WAKE_W'(1);
    localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(PWRUP_CLKS - 1);
    localparam logic [DATA_W-1:0] RES_ONE   = DATA_W'(1);

    sq_state_t         state;
    logic [CNT_W-1:0]  per_cnt, nxt_cnt, cal_len, tot_len, go_cal, go_tot;
    logic [WAKE_W-1:0] wake_cnt;
    logic              pend;
    logic [1:0]        go_mode;

    // Pick the mode whose lengths a sequence start would load.
    always_comb go_mode = (state == SQ_WAKE) ? mode_q : setup_mode;

    // Calibration and total period counts for each mode.
    always_comb begin
        case (go_mode)
            MD_SELF: begin go_cal = CNT_W'(SELF_CAL_PER); go_tot = CNT_W'(SELF_TOT); end
            MD_ZERO,
            MD_FULL: begin go_cal = CNT_W'(SYS_CAL_PER);  go_tot = CNT_W'(SYS_TOT);  end
            default: begin go_cal = '0;                   go_tot = CNT_W'(WAKE_PER); end
        endcase
    end

    // Next period count and the end-of-calibration pulse.
    always_comb begin
        nxt_cnt  = per_cnt + CNT_ONE;
        cal_done = (state == SQ_SEQ) && !wr_acc && odr_tick && !pd_enter &&
                   (cal_len != '0) && (nxt_cnt == cal_len);
    end

    // Main sequencer state, counters, data-ready and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_CONV;
            per_cnt  <= '0;
            cal_len  <= '0;
            tot_len  <= '0;
            wake_cnt <= '0;
            drdy_n   <= 1'b1;
            pend     <= 1'b0;
            result   <= '0;
        end else begin
            if (pend && mod_edge) begin
                drdy_n <= 1'b1;
                pend   <= 1'b0;
            end
            if (pd_enter) begin
                state <= SQ_PD;
                pend  <= 1'b0;
            end else begin
                case (state)
                    SQ_CONV: begin
                        if (wr_acc && setup_mode != MD_NORMAL) begin
                            state   <= SQ_SEQ;
                            per_cnt <= '0;
                            cal_len <= go_cal;
                            tot_len <= go_tot;
                            if (!drdy_n) pend <= 1'b1;
                        end else if (odr_tick) begin
                            result <= result + RES_ONE;
                            drdy_n <= 1'b0;
                            pend   <= 1'b0;
                        end else if (data_rd) begin
                            drdy_n <= 1'b1;
                        end
                    end
                    SQ_SEQ: begin
                        if (wr_acc) begin
                            if (setup_mode == MD_NORMAL) begin
                                state <= SQ_CONV;
                            end else begin
                                per_cnt <= '0;
                                cal_len <= go_cal;
                                tot_len <= go_tot;
                            end
                        end else if (odr_tick) begin
                            per_cnt <= nxt_cnt;
                            if (nxt_cnt == tot_len) begin
                                result <= result + RES_ONE;
                                drdy_n <= 1'b0;
                                pend   <= 1'b0;
                                state  <= SQ_CONV;
                            end
                        end
                    end
                    SQ_PD: begin
                        if (pd_exit) begin
                            state    <= SQ_WAKE;
                            wake_cnt <= '0;
                            drdy_n   <= 1'b1;
                        end else if (data_rd) begin
                            drdy_n <= 1'b1;
                        end
                    end
                    default: begin
                        if (wake_cnt == WAKE_LAST) begin
                            state   <= SQ_SEQ;
                            per_cnt <= '0;
                            cal_len <= go_cal;
                            tot_len <= go_tot;
                        end else begin
                            wake_cnt <= wake_cnt + WAKE_ONE;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/cal_drdy_seq.sv
// Top of the calibration and data-ready sequencer: register decode,
// modulator timebase and sequencing core.
// Assumes: odr_tick is a one-cycle strobe; at most one write strobe per cycle.
module cal_drdy_seq #(
    parameter int DATA_W        = 16,
    parameter int MOD_CLKS      = 128,
    parameter int SELF_CAL_PER  = 6,
    parameter int SELF_CONV_PER = 3,
    parameter int SYS_CAL_PER   = 3,
    parameter int SYS_CONV_PER  = 1,
    parameter int WAKE_PER      = 3,
    parameter int PWRUP_CLKS    = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              odr_tick,
    input  logic              setup_wr,
    input  logic [1:0]        setup_mode,
    input  logic              setup_fsync,
    input  logic              comm_wr,
    input  logic              comm_pwrdn,
    input  logic              clkout_off,
    input  logic              data_rd,
    output logic              drdy_n,
    output logic [1:0]        mode_rd,
    output logic              pwrdn_rd,
    output logic [DATA_W-1:0] result,
    output logic              clk_out
);
    logic cal_done, wr_acc, pd_enter, pd_exit, mod_edge;

    cds_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .setup_wr(setup_wr), .setup_mode(setup_mode), .setup_fsync(setup_fsync),
        .comm_wr(comm_wr), .comm_pwrdn(comm_pwrdn), .cal_done(cal_done),
        .mode_q(mode_rd), .pd_q(pwrdn_rd),
        .wr_acc(wr_acc), .pd_enter(pd_enter), .pd_exit(pd_exit)
    );

    cds_timebase #(.MOD_CLKS(MOD_CLKS)) u_tb (
        .clk(clk), .rst_n(rst_n), .clkout_off(clkout_off),
        .mod_edge(mod_edge), .clk_out(clk_out)
    );

    cds_fsm #(
        .DATA_W(DATA_W), .SELF_CAL_PER(SELF_CAL_PER), .SELF_CONV_PER(SELF_CONV_PER),
        .SYS_CAL_PER(SYS_CAL_PER), .SYS_CONV_PER(SYS_CONV_PER),
        .WAKE_PER(WAKE_PER), .PWRUP_CLKS(PWRUP_CLKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .odr_tick(odr_tick), .data_rd(data_rd),
        .mod_edge(mod_edge), .wr_acc(wr_acc), .setup_mode(setup_mode),
        .mode_q(mode_rd), .pd_enter(pd_enter), .pd_exit(pd_exit),
        .cal_done(cal_done), .drdy_n(drdy_n), .result(result)
    );
endmodule

// File: rtl/cds_checker.sv
// Property checker for cal_drdy_seq, attached with bind.
// Assumes: reset is held for at least two clocks.
module cds_checker #(
    parameter int DATA_W   = 16,
    parameter int MOD_CLKS = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              odr_tick,
    input logic              setup_wr,
    input logic [1:0]        setup_mode,
    input logic              setup_fsync,
    input logic              comm_wr,
    input logic              clkout_off,
    input logic              data_rd,
    input logic              drdy_n,
    input logic [1:0]        mode_rd,
    input logic              pwrdn_rd,
    input logic [DATA_W-1:0] result,
    input logic              clk_out
);
    localparam int CW = $clog2(MOD_CLKS + 2) + 1;
    localparam logic [CW-1:0] C_ONE = CW'(1);
    localparam logic [CW-1:0] C_MAX = CW'(MOD_CLKS + 1);

    logic          cal_start;
    logic [CW-1:0] low_cnt;

    // A write that starts a calibration while powered up.
    always_comb cal_start = setup_wr && (setup_mode != 2'b00) &&
                            !(setup_fsync && setup_mode != 2'b11) && !pwrdn_rd && !comm_wr;

    // Clocks that data-ready has stayed low since a calibration start.
    always_ff @(posedge clk) begin
        if (!rst_n || drdy_n || pwrdn_rd)       low_cnt <= '0;
        else if (cal_start)                     low_cnt <= C_ONE;
        else if (odr_tick)                      low_cnt <= '0;
        else if (low_cnt != '0)                 low_cnt <= low_cnt + C_ONE;
    end

    AST_MODE_CLEAR_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> mode_rd == 2'b00);                              // R6
    AST_RESULT_LOADED_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> result != $past(result));                       // R2
    AST_RISE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= C_MAX);                                                // R7
    AST_PD_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_rd |=> $stable(result));                                    // R10
    AST_PD_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn_rd && !drdy_n && !data_rd && !comm_wr) |=> !drdy_n);       // R11
    AST_PD_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn_rd && drdy_n) |=> drdy_n);                                 // R12
    AST_CLKOUT_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clkout_off)) |-> clk_out != $past(clk_out)); // R14
    AST_CLKOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clkout_off)) |-> !clk_out);                // R14
endmodule

bind cal_drdy_seq cds_checker #(.DATA_W(DATA_W), .MOD_CLKS(MOD_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .odr_tick(odr_tick), .setup_wr(setup_wr),
    .setup_mode(setup_mode), .setup_fsync(setup_fsync), .comm_wr(comm_wr),
    .clkout_off(clkout_off), .data_rd(data_rd), .drdy_n(drdy_n),
    .mode_rd(mode_rd), .pwrdn_rd(pwrdn_rd), .result(result), .clk_out(clk_out)
);

// File: tb/cal_drdy_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks push expected results, a monitor pops
// them at each fall of data-ready.
module cal_drdy_seq_bench;
    localparam int DW    = 16;
    localparam int MODC  = 128;
    localparam int PWRUP = 2000;
    localparam int GAP   = 140;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          odr_tick = 1'b0, setup_wr = 1'b0, setup_fsync = 1'b0;
    logic [1:0]    setup_mode = 2'b00;
    logic          comm_wr = 1'b0, comm_pwrdn = 1'b0, clkout_off = 1'b0, data_rd = 1'b0;
    logic          drdy_n, pwrdn_rd, clk_out;
    logic [1:0]    mode_rd;
    logic [DW-1:0] result;

    int            n_tests = 0, n_fail = 0;
    int            exp_res = 0;
    int            exp_q[$];
    logic          prev_n = 1'b1;
    logic          done = 1'b0;

    always #2.5 clk = ~clk;

    cal_drdy_seq #(.DATA_W(DW), .MOD_CLKS(MODC), .PWRUP_CLKS(PWRUP)) u_cal_drdy_seq (
        .clk(clk), .rst_n(rst_n), .odr_tick(odr_tick), .setup_wr(setup_wr),
        .setup_mode(setup_mode), .setup_fsync(setup_fsync), .comm_wr(comm_wr),
        .comm_pwrdn(comm_pwrdn), .clkout_off(clkout_off), .data_rd(data_rd),
        .drdy_n(drdy_n), .mode_rd(mode_rd), .pwrdn_rd(pwrdn_rd),
        .result(result), .clk_out(clk_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_next();
        exp_res++;
        exp_q.push_back(exp_res);
    endtask

    task automatic tick();
        repeat (GAP) @(negedge clk);
        odr_tick = 1'b1;
        @(negedge clk);
        odr_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic setup(input logic [1:0] m, input logic fs);
        @(negedge clk);
        setup_wr = 1'b1; setup_mode = m; setup_fsync = fs;
        @(negedge clk);
        setup_wr = 1'b0;
    endtask

    task automatic comm(input logic pd);
        @(negedge clk);
        comm_wr = 1'b1; comm_pwrdn = pd;
        @(negedge clk);
        comm_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Monitor: each fall of data-ready must match the oldest expected result.
    always @(negedge clk) begin
        if (rst_n && prev_n && !drdy_n) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected result %0d, expected none", result);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(result) != e) begin
                    n_fail++;
                    $display("FAIL R2: result %0d expected %0d", result, e);
                end
            end
        end
        prev_n = drdy_n;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int r0, waited;
        logic c0;
        repeat (4) @(negedge clk);
        chk("R1 drdy", drdy_n, 1);
        chk("R1 mode", mode_rd, 0);
        chk("R1 pwrdn", pwrdn_rd, 0);
        chk("R1 result", result, 0);
        chk("R1 clk_out", clk_out, 0);
        rst_n = 1'b1;

        // R2 normal conversions
        expect_next(); tick();
        chk("R2 drdy low", drdy_n, 0);
        rd();
        chk("R2 drdy high after read", drdy_n, 1);
        expect_next(); tick();
        chk("R2 second drdy low", drdy_n, 0);

        // R7 / R3 self-calibration started with data-ready low
        setup(2'b01, 1'b0);
        waited = 0;
        while (!drdy_n && waited < MODC + 2) begin @(negedge clk); waited++; end
        chk("R7 rise within modulator cycle", drdy_n, 1);
        chk("R3 mode set", mode_rd, 1);
        r0 = result;
        ticks(5);
        chk("R3 mode before 6th", mode_rd, 1);
        tick();
        chk("R3 mode after 6th", mode_rd, 0);
        ticks(2);
        chk("R7 drdy high in cal", drdy_n, 1);
        chk("R7 no load in cal", result, r0);
        expect_next(); tick();
        chk("R3 drdy after 9th", drdy_n, 0);
        rd();

        // R4 zero-scale
        setup(2'b10, 1'b0);
        chk("R7 stays high", drdy_n, 1);
        ticks(2);
        chk("R4 mode before 3rd", mode_rd, 2);
        tick();
        chk("R4 mode after 3rd", mode_rd, 0);
        chk("R4 drdy high after 3rd", drdy_n, 1);
        expect_next(); tick();
        chk("R4 drdy after 4th", drdy_n, 0);
        rd();

        // R5 full-scale with filter-sync 1
        setup(2'b11, 1'b1);
        chk("R5 mode set", mode_rd, 3);
        ticks(3);
        chk("R5 mode after 3rd", mode_rd, 0);
        expect_next(); tick();
        chk("R5 drdy after 4th", drdy_n, 0);
        rd();

        // R9 ignored writes
        setup(2'b01, 1'b1);
        chk("R9 mode after 01/fsync", mode_rd, 0);
        setup(2'b10, 1'b1);
        chk("R9 mode after 10/fsync", mode_rd, 0);
        expect_next(); tick();
        chk("R9 normal result", drdy_n, 0);
        rd();

        // R8 abort and restart
        setup(2'b01, 1'b0);
        ticks(4);
        chk("R8 mode mid self-cal", mode_rd, 1);
        setup(2'b10, 1'b0);
        chk("R8 new mode", mode_rd, 2);
        ticks(3);
        chk("R8 mode cleared", mode_rd, 0);
        chk("R8 drdy high", drdy_n, 1);
        expect_next(); tick();
        chk("R8 drdy after restart", drdy_n, 0);
        rd();

        // R12 / R10 power-down with data-ready high
        r0 = result;
        comm(1'b1);
        chk("R10 pwrdn set", pwrdn_rd, 1);
        chk("R12 drdy kept high", drdy_n, 1);
        ticks(2);
        chk("R12 drdy high in pd", drdy_n, 1);
        chk("R10 result frozen", result, r0);
        chk("R10 mode kept", mode_rd, 0);
        c0 = clk_out;
        @(negedge clk);
        chk("R14 clk_out runs in pd", clk_out, int'(!c0));

        // R13 wake in normal mode
        comm(1'b0);
        chk("R13 pwrdn clear", pwrdn_rd, 0);
        repeat (1000) @(negedge clk);
        tick();
        repeat (1100) @(negedge clk);
        ticks(2);
        chk("R13 no result before 3rd", drdy_n, 1);
        expect_next(); tick();
        chk("R13 result after wake", drdy_n, 0);

        // R11 read in power-down
        r0 = result;
        comm(1'b1);
        chk("R10 drdy low kept", drdy_n, 0);
        tick();
        chk("R11 drdy low in pd", drdy_n, 0);
        chk("R11 result frozen", result, r0);
        rd();
        chk("R11 read raises drdy", drdy_n, 1);
        setup(2'b11, 1'b0);
        chk("R10 mode written in pd", mode_rd, 3);
        chk("R10 drdy unchanged by write", drdy_n, 1);

        // R13 wake with stored full-scale calibration
        comm(1'b0);
        repeat (PWRUP + 100) @(negedge clk);
        ticks(3);
        chk("R13 cal mode cleared", mode_rd, 0);
        chk("R13 no result yet", drdy_n, 1);
        expect_next(); tick();
        chk("R13 cal result", drdy_n, 0);

        // R11 unread data held through power-down
        comm(1'b1);
        ticks(2);
        chk("R11 unread stays low", drdy_n, 0);
        comm(1'b0);
        chk("R11 rises on exit", drdy_n, 1);
        repeat (PWRUP + 100) @(negedge clk);
        ticks(2);
        expect_next(); tick();
        chk("R13 second wake result", drdy_n, 0);
        rd();

        // R14 clock output disable
        clkout_off = 1'b1;
        repeat (2) @(negedge clk);
        chk("R14 held low", clk_out, 0);
        @(negedge clk);
        chk("R14 still low", clk_out, 0);
        clkout_off = 1'b0;
        repeat (2) @(negedge clk);
        c0 = clk_out;
        @(negedge clk);
        chk("R14 toggles", clk_out, int'(!c0));

        chk("R2 all results seen", exp_q.size(), 0);
        finish_run();
    end
endmodule